// File: doc/BRIEF.md
# Command Mailbox Register Target

This block is the device side of a host-to-device command mailbox. A host on a 32-bit word-addressed slave port stages up to seven parameter words and then writes a packed command word. The command word marks the mailbox busy. It also fires a single-cycle strobe toward an internal executor, which receives the decoded command fields and every parameter word.

When the executor reports completion, the block captures three response words and a status word in one cycle. The status word holds a short result, two error codes and a ready flag. In the same cycle the command word returns to zero, so the host learns that the mailbox is free by polling that register. The host then acknowledges the response by writing a zero into the ready flag. The other status fields are left untouched by that write.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset, the command, status, parameter and response registers all read as zero, and the command strobe is low.
- R2: Parameter word k (k = 0..6) is at byte offset 0x438 - 4k. While no command is in flight, a write to that offset is read back unchanged from it.
- R3: A non-zero write to the command register (offset 0x43C) while it reads zero pulses the command strobe high for exactly one cycle, starting in the cycle after the write. The executor then sees target type = bits 31:29, instance ID = bits 28:24, command type = bits 23:16, opcode = bits 15:0, and parameter word k on bits 32k+31:32k of the parameter bus.
- R4: While a command is in flight, the command register reads back the command word that was posted.
- R5: While a command is in flight, writes to the command register and to the parameter registers are ignored. No strobe fires and the stored values are unchanged.
- R6: An executor done pulse during a command loads response word k at offset 0x458 - 4k (k = 0..2). In the same cycle it loads the status register at 0x45C as {short[15:0], 8'h00, cmdErr[2:0], genErr[3:0], 1'b1} and clears the command register to zero.
- R7: A write to the status register that has bit 0 clear clears the ready flag (bit 0). All other status bits keep their values, and writing 1 to bit 0 never sets the flag.
- R8: The response data registers are read-only. Reads of any unmapped or misaligned offset return zero.
- R9: Writing zero to the command register while idle starts nothing: no strobe fires and the register stays zero.
- R10: A parameter register the host did not rewrite keeps its earlier value, and that value is presented with the next command.
- R11: A done pulse while no command is in flight is ignored. The response and status registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Host write enable |
| busRdEn | input | 1 | Host read enable |
| busAddr | input | ADDR_W | Host byte address |
| busWrData | input | 32 | Host write data |
| busRdData | output | 32 | Read data, valid while busRdValid is high |
| busRdValid | output | 1 | Read data valid, one cycle after busRdEn |
| cmdStrobe | output | 1 | One-cycle command start pulse to the executor |
| cmdTgtType | output | 3 | Target type field of the posted command |
| cmdInstId | output | 5 | Target instance ID field |
| cmdType | output | 8 | Command type field |
| cmdOpcode | output | 16 | Opcode field |
| cmdParams | output | NUM_PARAM*32 | All parameter words, word k in bits 32k+31:32k |
| exeDone | input | 1 | Executor completion pulse |
| exeRespData | input | NUM_RESP*32 | Response words, word k in bits 32k+31:32k |
| exeShort | input | 16 | Short result value |
| exeCmdErr | input | 3 | Command-response error code |
| exeGenErr | input | 4 | General error code |

## Verification
The bench builds the block with its default parameters: a 12-bit address, seven parameter words and three response words. With these values the full offset map is in range, and so are the unmapped holes just above the command register and just below the last parameter word, along with a misaligned status address. A stub executor driven from the bench tasks supplies done pulses both during a command and while idle. This covers both the accepted and the ignored completion paths, as well as stale-parameter carry-over between two commands.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam int unsigned REQ_OFF    = 32'h43C;
  localparam int unsigned STAT_OFF   = 32'h45C;
  localparam int unsigned PARAM_BASE = 32'h438;
  localparam int unsigned RESP_BASE  = 32'h458;

  // Strobes from control to datapath
  typedef struct packed {
    logic reqLoad;   // accept a new command word
    logic doneLoad;  // capture executor response, free the mailbox
    logic statWr;    // host write to status register
  } mbxStrobes_t;

  function automatic int unsigned paramOff(int unsigned k);
    return PARAM_BASE - 4 * k;
  endfunction

  function automatic int unsigned respOff(int unsigned k);
    return RESP_BASE - 4 * k;
  endfunction

endpackage

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_PARAM = 7
) (
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  input  logic              busy,
  input  logic              exeDone,
  output mbxStrobes_t       strb,
  output logic [NUM_PARAM-1:0] paramWe
);

  logic hitReq;
  logic hitStat;

  assign hitReq  = (busAddr == ADDR_W'(REQ_OFF));
  assign hitStat = (busAddr == ADDR_W'(STAT_OFF));

  always_comb begin
    strb.reqLoad  = busWrEn && hitReq && !busy && (busWrData != '0);
    strb.doneLoad = exeDone && busy;
    strb.statWr   = busWrEn && hitStat;
  end

  for (genvar k = 0; k < NUM_PARAM; k++) begin : g_pwe
    assign paramWe[k] = busWrEn && !busy && (busAddr == ADDR_W'(paramOff(k)));
  end

endmodule

// File: rtl/mbx_dp.sv
module mbx_dp
  import mbx_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_PARAM = 7,
  parameter int NUM_RESP  = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  mbxStrobes_t             strb,
  input  logic [NUM_PARAM-1:0]    paramWe,
  input  logic [31:0]             busWrData,
  input  logic                    busRdEn,
  input  logic [ADDR_W-1:0]       busAddr,
  output logic [31:0]             busRdData,
  output logic                    busRdValid,
  input  logic [NUM_RESP*32-1:0]  exeRespData,
  input  logic [15:0]             exeShort,
  input  logic [2:0]              exeCmdErr,
  input  logic [3:0]              exeGenErr,
  output logic                    busy,
  output logic                    ready,
  output logic                    cmdStrobe,
  output logic [2:0]              cmdTgtType,
  output logic [4:0]              cmdInstId,
  output logic [7:0]              cmdType,
  output logic [15:0]             cmdOpcode,
  output logic [NUM_PARAM*32-1:0] cmdParams
);

  logic [31:0] reqQ;
  logic [31:0] statQ;
  logic [31:0] paramQ [NUM_PARAM];
  logic [31:0] respQ  [NUM_RESP];
  logic        strobeQ;
  logic [31:0] rdMux;

  // Command word doubles as busy flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqQ    <= '0;
      strobeQ <= 1'b0;
    end else begin
      strobeQ <= strb.reqLoad;
      if (strb.doneLoad)     reqQ <= '0;
      else if (strb.reqLoad) reqQ <= busWrData;
    end
  end

  for (genvar k = 0; k < NUM_PARAM; k++) begin : g_param
    always_ff @(posedge clk) begin
      if (!rstN)           paramQ[k] <= '0;
      else if (paramWe[k]) paramQ[k] <= busWrData;
    end
    assign cmdParams[k*32 +: 32] = paramQ[k];
  end

  for (genvar k = 0; k < NUM_RESP; k++) begin : g_resp
    always_ff @(posedge clk) begin
      if (!rstN)              respQ[k] <= '0;
      else if (strb.doneLoad) respQ[k] <= exeRespData[k*32 +: 32];
    end
  end

  // Status: completion wins over a same-cycle host acknowledge
  always_ff @(posedge clk) begin
    if (!rstN)              statQ <= '0;
    else if (strb.doneLoad) statQ <= {exeShort, 8'h00, exeCmdErr, exeGenErr, 1'b1};
    else if (strb.statWr)   statQ[0] <= statQ[0] & busWrData[0];
  end

  always_comb begin
    rdMux = '0;
    if (busAddr == ADDR_W'(REQ_OFF))  rdMux = reqQ;
    if (busAddr == ADDR_W'(STAT_OFF)) rdMux = statQ;
    for (int k = 0; k < NUM_PARAM; k++)
      if (busAddr == ADDR_W'(paramOff(k))) rdMux = paramQ[k];
    for (int k = 0; k < NUM_RESP; k++)
      if (busAddr == ADDR_W'(respOff(k))) rdMux = respQ[k];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdData  <= '0;
      busRdValid <= 1'b0;
    end else begin
      busRdValid <= busRdEn;
      if (busRdEn) busRdData <= rdMux;
    end
  end

  assign busy       = (reqQ != '0);
  assign ready      = statQ[0];
  assign cmdStrobe  = strobeQ;
  assign cmdTgtType = reqQ[31:29];
  assign cmdInstId  = reqQ[28:24];
  assign cmdType    = reqQ[23:16];
  assign cmdOpcode  = reqQ[15:0];

endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
  import mbx_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_PARAM = 7,
  parameter int NUM_RESP  = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    busWrEn,
  input  logic                    busRdEn,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic [31:0]             busWrData,
  output logic [31:0]             busRdData,
  output logic                    busRdValid,
  output logic                    cmdStrobe,
  output logic [2:0]              cmdTgtType,
  output logic [4:0]              cmdInstId,
  output logic [7:0]              cmdType,
  output logic [15:0]             cmdOpcode,
  output logic [NUM_PARAM*32-1:0] cmdParams,
  input  logic                    exeDone,
  input  logic [NUM_RESP*32-1:0]  exeRespData,
  input  logic [15:0]             exeShort,
  input  logic [2:0]              exeCmdErr,
  input  logic [3:0]              exeGenErr
);

  mbxStrobes_t          strbW;
  logic [NUM_PARAM-1:0] paramWeW;
  logic                 busyW;
  logic                 readyW;

  mbx_ctrl #(.ADDR_W(ADDR_W), .NUM_PARAM(NUM_PARAM)) u_ctrl (
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busy      (busyW),
    .exeDone   (exeDone),
    .strb      (strbW),
    .paramWe   (paramWeW)
  );

  mbx_dp #(.ADDR_W(ADDR_W), .NUM_PARAM(NUM_PARAM), .NUM_RESP(NUM_RESP)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strbW),
    .paramWe     (paramWeW),
    .busWrData   (busWrData),
    .busRdEn     (busRdEn),
    .busAddr     (busAddr),
    .busRdData   (busRdData),
    .busRdValid  (busRdValid),
    .exeRespData (exeRespData),
    .exeShort    (exeShort),
    .exeCmdErr   (exeCmdErr),
    .exeGenErr   (exeGenErr),
    .busy        (busyW),
    .ready       (readyW),
    .cmdStrobe   (cmdStrobe),
    .cmdTgtType  (cmdTgtType),
    .cmdInstId   (cmdInstId),
    .cmdType     (cmdType),
    .cmdOpcode   (cmdOpcode),
    .cmdParams   (cmdParams)
  );

endmodule

// File: rtl/cmd_mailbox_chk.sv
module cmd_mailbox_chk
  import mbx_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_PARAM = 7
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    busWrEn,
  input logic [ADDR_W-1:0]       busAddr,
  input logic [31:0]             busWrData,
  input logic                    exeDone,
  input logic                    cmdStrobe,
  input logic [2:0]              cmdTgtType,
  input logic [4:0]              cmdInstId,
  input logic [7:0]              cmdType,
  input logic [15:0]             cmdOpcode,
  input logic [NUM_PARAM*32-1:0] cmdParams,
  input logic                    busyW,
  input logic                    readyW
);

  // R3: strobe is a single-cycle pulse
  p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe |=> !cmdStrobe);

  // R3, R9: strobe only follows an accepted non-zero command write
  p_strobe_cause_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe |-> $past(busWrEn && busAddr == ADDR_W'(REQ_OFF) && busWrData != '0 && !busyW));

  // R5: command fields and parameters frozen while in flight
  p_fields_frozen_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busyW && !exeDone) |=> ($stable({cmdTgtType, cmdInstId, cmdType, cmdOpcode}) && $stable(cmdParams) && busyW));

  // R6: done frees mailbox and raises ready
  p_done_completes_r6: assert property (@(posedge clk) disable iff (!rstN)
    (exeDone && busyW) |=> (readyW && !busyW));

  // R7: ready falls only through a host status write
  p_ready_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (readyW && !(busWrEn && busAddr == ADDR_W'(STAT_OFF))) |=> readyW);

  // R11: idle done leaves ready unchanged
  p_idle_done_r11: assert property (@(posedge clk) disable iff (!rstN)
    (exeDone && !busyW && !(busWrEn && busAddr == ADDR_W'(STAT_OFF))) |=> $stable(readyW));

endmodule

bind cmd_mailbox cmd_mailbox_chk #(.ADDR_W(ADDR_W), .NUM_PARAM(NUM_PARAM)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busWrEn    (busWrEn),
  .busAddr    (busAddr),
  .busWrData  (busWrData),
  .exeDone    (exeDone),
  .cmdStrobe  (cmdStrobe),
  .cmdTgtType (cmdTgtType),
  .cmdInstId  (cmdInstId),
  .cmdType    (cmdType),
  .cmdOpcode  (cmdOpcode),
  .cmdParams  (cmdParams),
  .busyW      (busyW),
  .readyW     (readyW)
);

// File: tb/cmd_mailbox_tb.sv
module cmd_mailbox_tb;

  localparam int ADDR_W    = 12;
  localparam int NUM_PARAM = 7;
  localparam int NUM_RESP  = 3;

  localparam logic [ADDR_W-1:0] A_REQ   = 12'h43C;
  localparam logic [ADDR_W-1:0] A_STAT  = 12'h45C;
  localparam logic [ADDR_W-1:0] A_RESP0 = 12'h458;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic busRdValid;
  logic cmdStrobe;
  logic [2:0] cmdTgtType;
  logic [4:0] cmdInstId;
  logic [7:0] cmdType;
  logic [15:0] cmdOpcode;
  logic [NUM_PARAM*32-1:0] cmdParams;
  logic exeDone = 1'b0;
  logic [NUM_RESP*32-1:0] exeRespData = '0;
  logic [15:0] exeShort = '0;
  logic [2:0] exeCmdErr = '0;
  logic [3:0] exeGenErr = '0;

  int nChecks = 0;
  int nFails = 0;

  always #4 clk = ~clk;

  cmd_mailbox #(.ADDR_W(ADDR_W), .NUM_PARAM(NUM_PARAM), .NUM_RESP(NUM_RESP)) u_dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .busRdValid(busRdValid),
    .cmdStrobe(cmdStrobe), .cmdTgtType(cmdTgtType), .cmdInstId(cmdInstId),
    .cmdType(cmdType), .cmdOpcode(cmdOpcode), .cmdParams(cmdParams),
    .exeDone(exeDone), .exeRespData(exeRespData), .exeShort(exeShort),
    .exeCmdErr(exeCmdErr), .exeGenErr(exeGenErr)
  );

  function automatic logic [ADDR_W-1:0] pAddr(int k);
    return ADDR_W'(32'h438 - 4 * k);
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, got, exp);
    end
  endtask

  task automatic wrBus(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rdBus(logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  task automatic pulseDone(logic [31:0] r0, logic [31:0] r1, logic [31:0] r2,
                           logic [15:0] sh, logic [2:0] ce, logic [3:0] ge);
    @(negedge clk);
    exeDone = 1'b1; exeRespData = {r2, r1, r0};
    exeShort = sh; exeCmdErr = ce; exeGenErr = ge;
    @(negedge clk);
    exeDone = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 strobe", {31'b0, cmdStrobe}, 32'h0);
    rdBus(A_REQ, v);   check("R1 req", v, 32'h0);
    rdBus(A_STAT, v);  check("R1 status", v, 32'h0);
    rdBus(pAddr(0), v); check("R1 param0", v, 32'h0);
    rdBus(A_RESP0, v); check("R1 resp0", v, 32'h0);
  endtask

  task automatic t_params();
    logic [31:0] v;
    for (int k = 0; k < NUM_PARAM; k++) wrBus(pAddr(k), 32'hA000_0000 + k);
    for (int k = 0; k < NUM_PARAM; k++) begin
      rdBus(pAddr(k), v);
      check($sformatf("R2 param%0d", k), v, 32'hA000_0000 + k);
    end
  endtask

  task automatic t_post();
    logic [31:0] v;
    wrBus(A_REQ, 32'hB13C_0041);
    check("R3 strobe high", {31'b0, cmdStrobe}, 32'h1);
    check("R3 fields", {cmdTgtType, cmdInstId, cmdType, cmdOpcode}, 32'hB13C_0041);
    check("R3 type", {29'b0, cmdTgtType}, 32'h5);
    check("R3 inst", {27'b0, cmdInstId}, 32'h11);
    check("R3 param0 bus", cmdParams[0 +: 32], 32'hA000_0000);
    check("R3 param6 bus", cmdParams[6*32 +: 32], 32'hA000_0006);
    @(negedge clk);
    check("R3 strobe one cycle", {31'b0, cmdStrobe}, 32'h0);
    rdBus(A_REQ, v); check("R4 req busy", v, 32'hB13C_0041);
  endtask

  task automatic t_busyIgnore();
    logic [31:0] v;
    wrBus(pAddr(0), 32'h1234_5678);
    wrBus(A_REQ, 32'h2222_2222);
    check("R5 no strobe", {31'b0, cmdStrobe}, 32'h0);
    rdBus(pAddr(0), v); check("R5 param0 kept", v, 32'hA000_0000);
    rdBus(A_REQ, v);    check("R5 req kept", v, 32'hB13C_0041);
  endtask

  task automatic t_done();
    logic [31:0] v;
    pulseDone(32'h1111_0000, 32'h2222_0000, 32'h3333_0000, 16'hBEEF, 3'd5, 4'd6);
    rdBus(A_STAT, v);       check("R6 status", v, 32'hBEEF_00AD);
    rdBus(12'h458, v);      check("R6 resp0", v, 32'h1111_0000);
    rdBus(12'h454, v);      check("R6 resp1", v, 32'h2222_0000);
    rdBus(12'h450, v);      check("R6 resp2", v, 32'h3333_0000);
    rdBus(A_REQ, v);        check("R6 req cleared", v, 32'h0);
  endtask

  task automatic t_ack();
    logic [31:0] v;
    wrBus(A_STAT, 32'hFFFF_FFFE);
    rdBus(A_STAT, v); check("R7 ack clears ready only", v, 32'hBEEF_00AC);
    wrBus(A_STAT, 32'h0000_0001);
    rdBus(A_STAT, v); check("R7 write one no set", v, 32'hBEEF_00AC);
  endtask

  task automatic t_readOnly();
    logic [31:0] v;
    wrBus(A_RESP0, 32'hDEAD_BEEF);
    rdBus(A_RESP0, v);  check("R8 resp read-only", v, 32'h1111_0000);
    rdBus(12'h440, v);  check("R8 unmapped 440", v, 32'h0);
    rdBus(12'h41C, v);  check("R8 unmapped 41C", v, 32'h0);
    rdBus(12'h000, v);  check("R8 unmapped 000", v, 32'h0);
    rdBus(12'h45A, v);  check("R8 misaligned", v, 32'h0);
  endtask

  task automatic t_zeroReq();
    logic [31:0] v;
    wrBus(A_REQ, 32'h0);
    check("R9 no strobe", {31'b0, cmdStrobe}, 32'h0);
    rdBus(A_REQ, v); check("R9 req zero", v, 32'h0);
  endtask

  task automatic t_stale();
    logic [31:0] v;
    wrBus(pAddr(2), 32'h55AA_55AA);
    wrBus(A_REQ, 32'h2001_0002);
    check("R10 strobe", {31'b0, cmdStrobe}, 32'h1);
    check("R10 stale param1", cmdParams[1*32 +: 32], 32'hA000_0001);
    check("R10 new param2", cmdParams[2*32 +: 32], 32'h55AA_55AA);
    check("R10 stale param6", cmdParams[6*32 +: 32], 32'hA000_0006);
    pulseDone(32'h1, 32'h2, 32'h3, 16'h0001, 3'd0, 4'd0);
    rdBus(A_STAT, v); check("R10 second status", v, 32'h0001_0001);
  endtask

  task automatic t_idleDone();
    logic [31:0] v;
    pulseDone(32'hFFFF, 32'hEEEE, 32'hDDDD, 16'h7777, 3'd7, 4'd15);
    rdBus(A_STAT, v);  check("R11 status kept", v, 32'h0001_0001);
    rdBus(A_RESP0, v); check("R11 resp0 kept", v, 32'h1);
    rdBus(A_REQ, v);   check("R11 req idle", v, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_params();
    t_post();
    t_busyIgnore();
    t_done();
    t_ack();
    t_readOnly();
    t_zeroReq();
    t_stale();
    t_idleDone();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule